// File: doc/BRIEF.md
# Coalescing One-Shot Timer Requester

This block sits between a stream of timer deadlines and a remote one-shot timer that counts in whole microseconds. Each deadline arrives as an absolute timebase value. The block decides whether the remote timer needs a new start command. If it does, it issues a start request carrying a microsecond count. That count is the remaining time rounded up, with a floor at a minimum period.

Only one start command is outstanding at a time. Deadlines that arrive while a command is in flight are folded together so that only the earliest survives. That earliest deadline is sent once the command completes. While a timer is already armed, the block re-arms it only when doing so saves a deadline that the running timer would miss. Re-arms are capped between expiries.

A watchdog watches the armed timer. If the timer's expected expiry slips far into the past with no expiry event, the block raises a stuck flag and stops issuing commands for good. The host then falls back to another way of timing.

Top module: `oneshot_arm_ctrl`

## Requirements
- R1: A start count is never below MIN_US (500). It is exactly MIN_US when the target is MIN_US*TICKS_PER_US ticks or fewer ahead of the current timebase, or is already in the past.
- R2: When the target is more than MIN_US*TICKS_PER_US ticks ahead, the count is the remaining ticks divided by TICKS_PER_US, rounded up.
- R3: While the timer is running, a target produces no start in any of three cases: the target is at or after the expected expiry, the current timebase is at or past the expected expiry, or at most MIN_US*TICKS_PER_US ticks remain before it.
- R4: At most MAX_UPD (2) starts are issued between expiry events. Any expiry event, wanted or not, resets that allowance.
- R5: While a start command is in flight, a new target replaces the stored one only if it is strictly earlier. The stored target is evaluated for a start in the cycle after the command completes.
- R6: A target equal to the stored target has no effect.
- R7: A completion with cmd_ok high marks the timer running. The expected expiry becomes the timebase at completion plus start_us*TICKS_PER_US ticks.
- R8: When the timer is running and the timebase exceeds the expected expiry by more than STUCK_US*TICKS_PER_US ticks, stuck goes high in the next cycle. It stays high until reset, and no start is issued after that.
- R9: A completion with cmd_ok low leaves the running state unchanged. A target recorded during that command is still evaluated after it.
- R10: After reset, start_req and stuck are low and no timer is running.
- R11: No start_req is issued while a previous start awaits its completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tgt_valid | input | 1 | New absolute target present this cycle |
| tgt_time | input | TB_W | Absolute target timebase value |
| now | input | TB_W | Current timebase value |
| cmd_done | input | 1 | Remote start command completed (one cycle) |
| cmd_ok | input | 1 | Completion status, high on success |
| expiry | input | 1 | Remote timer expiry event (one cycle) |
| start_req | output | 1 | One-cycle start command request |
| start_us | output | US_W | Microsecond count of the latest start |
| stuck | output | 1 | Timer declared stalled; no further use |

## Verification
The bench builds the block with TICKS_PER_US=4, MIN_US=500, MAX_UPD=2 and STUCK_US=10000. With a ratio of 4, the rounding edge is reached with plain numbers: 8001 ticks rounds up to 2001 us. The minimum-period margin is 2000 ticks and the stall window is 40000 ticks. The timebase is an input, so the bench jumps it straight across the stall window, one tick either side of the threshold, without spending cycles. It also drives the coalescing, rate-limit and failed-completion sequences cycle by cycle.

// File: rtl/oneshot_arm_pkg.sv
package oneshot_arm_pkg;

    // Why an evaluation did not produce a start command.
    typedef enum logic [2:0] {
        SKIP_NONE   = 3'd0,
        SKIP_LATER  = 3'd1,
        SKIP_PASSED = 3'd2,
        SKIP_SHORT  = 3'd3,
        SKIP_LIMIT  = 3'd4
    } skip_e;

    // Control flags of the requester.
    typedef struct packed {
        logic running;
        logic pending;
        logic inflight;
        logic stuck;
    } arm_flags_t;

    function automatic int unsigned ticks_of(input int unsigned us, input int unsigned per_us);
        return us * per_us;
    endfunction

endpackage

// File: rtl/osa_span_calc.sv
module osa_span_calc
    import oneshot_arm_pkg::*;
#(
    parameter int TB_W         = 32,
    parameter int US_W         = 32,
    parameter int TICKS_PER_US = 16,
    parameter int MIN_US       = 500,
    parameter int MAX_UPD      = 2,
    parameter int CNT_W        = 2
) (
    input  logic [TB_W-1:0]  target,
    input  logic [TB_W-1:0]  now,
    input  logic             running,
    input  logic [TB_W-1:0]  stamp,
    input  logic [CNT_W-1:0] upd_cnt,
    output skip_e            skip,
    output logic [US_W-1:0]  us_count
);
    localparam int unsigned MIN_TICKS = ticks_of(MIN_US, TICKS_PER_US);

    logic [TB_W-1:0] ahead;
    logic [TB_W:0]   rounded;

    always_comb begin
        skip = SKIP_NONE;
        if (running) begin
            if (target >= stamp)
                skip = SKIP_LATER;
            else if (now >= stamp)
                skip = SKIP_PASSED;
            else if ((stamp - now) <= TB_W'(MIN_TICKS))
                skip = SKIP_SHORT;
        end
        if (skip == SKIP_NONE && upd_cnt >= CNT_W'(MAX_UPD))
            skip = SKIP_LIMIT;
    end

    always_comb begin
        ahead    = target - now;
        rounded  = ({1'b0, ahead} + (TB_W+1)'(TICKS_PER_US - 1)) / (TB_W+1)'(TICKS_PER_US);
        us_count = US_W'(MIN_US);
        if (target > now && ahead > TB_W'(MIN_TICKS))
            us_count = US_W'(rounded);
    end
endmodule

// File: rtl/osa_stall_watch.sv
module osa_stall_watch
    import oneshot_arm_pkg::*;
#(
    parameter int TB_W         = 32,
    parameter int TICKS_PER_US = 16,
    parameter int STUCK_US     = 10000
) (
    input  logic            running,
    input  logic [TB_W-1:0] stamp,
    input  logic [TB_W-1:0] now,
    output logic            trip
);
    localparam int unsigned LIMIT_TICKS = ticks_of(STUCK_US, TICKS_PER_US);

    logic [TB_W:0] deadline;

    always_comb begin
        deadline = {1'b0, stamp} + (TB_W+1)'(LIMIT_TICKS);
        trip     = running && ({1'b0, now} > deadline);
    end
endmodule

// File: rtl/oneshot_arm_ctrl.sv
module oneshot_arm_ctrl
    import oneshot_arm_pkg::*;
#(
    parameter int TB_W         = 32,
    parameter int US_W         = 32,
    parameter int TICKS_PER_US = 16,
    parameter int MIN_US       = 500,
    parameter int MAX_UPD      = 2,
    parameter int STUCK_US     = 10000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tgt_valid,
    input  logic [TB_W-1:0] tgt_time,
    input  logic [TB_W-1:0] now,
    input  logic            cmd_done,
    input  logic            cmd_ok,
    input  logic            expiry,
    output logic            start_req,
    output logic [US_W-1:0] start_us,
    output logic            stuck
);
    localparam int CNT_W = $clog2(MAX_UPD + 1);

    logic [TB_W-1:0]  target;
    logic [TB_W-1:0]  stamp;
    logic [CNT_W-1:0] upd_cnt;
    arm_flags_t       fl;

    logic             take_new;
    logic             attempt;
    logic             issue;
    logic             trip;
    logic [TB_W-1:0]  cand;
    logic [US_W-1:0]  calc_us;
    skip_e            skip;

    // A differing target is taken when idle; otherwise only if it is earlier.
    always_comb begin
        take_new = tgt_valid && (tgt_time != target) &&
                   ((!fl.inflight && !fl.pending) || (tgt_time < target));
        cand     = take_new ? tgt_time : target;
        attempt  = !fl.stuck && !fl.inflight && (fl.pending || take_new);
        issue    = attempt && (skip == SKIP_NONE);
    end

    osa_span_calc #(
        .TB_W(TB_W), .US_W(US_W), .TICKS_PER_US(TICKS_PER_US),
        .MIN_US(MIN_US), .MAX_UPD(MAX_UPD), .CNT_W(CNT_W)
    ) u_span (
        .target(cand), .now(now), .running(fl.running), .stamp(stamp),
        .upd_cnt(upd_cnt), .skip(skip), .us_count(calc_us)
    );

    osa_stall_watch #(
        .TB_W(TB_W), .TICKS_PER_US(TICKS_PER_US), .STUCK_US(STUCK_US)
    ) u_watch (
        .running(fl.running), .stamp(stamp), .now(now), .trip(trip)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            target    <= '0;
            stamp     <= '1;
            upd_cnt   <= '0;
            fl        <= '0;
            start_req <= 1'b0;
            start_us  <= US_W'(MIN_US);
        end else begin
            start_req <= issue;
            if (take_new)
                target <= tgt_time;
            if (attempt)
                fl.pending <= 1'b0;
            else if (take_new && fl.inflight)
                fl.pending <= 1'b1;
            if (issue) begin
                start_us    <= calc_us;
                fl.inflight <= 1'b1;
            end
            if (expiry)
                upd_cnt <= '0;
            else if (issue)
                upd_cnt <= upd_cnt + CNT_W'(1);
            if (expiry)
                fl.running <= 1'b0;
            if (trip) begin
                fl.running <= 1'b0;
                fl.stuck   <= 1'b1;
            end
            if (cmd_done && fl.inflight) begin
                fl.inflight <= 1'b0;
                if (cmd_ok && !fl.stuck) begin
                    fl.running <= 1'b1;
                    stamp      <= now + TB_W'(start_us) * TB_W'(TICKS_PER_US);
                end
            end
        end
    end

    assign stuck = fl.stuck;

    assert_one_cmd_R11: assert property (@(posedge clk) disable iff (rst)
        fl.inflight |=> !start_req);

    assert_min_count_R1: assert property (@(posedge clk) disable iff (rst)
        start_req |-> (start_us >= US_W'(MIN_US)));

    assert_rate_limit_R4: assert property (@(posedge clk) disable iff (rst)
        start_req |-> (upd_cnt <= CNT_W'(MAX_UPD)));

    assert_stuck_hold_R8: assert property (@(posedge clk) disable iff (rst)
        fl.stuck |=> (fl.stuck && !start_req));
endmodule

// File: tb/test_oneshot_arm_ctrl.sv
module test_oneshot_arm_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        tgt_valid;
    logic [31:0] tgt_time;
    logic [31:0] now;
    logic        cmd_done;
    logic        cmd_ok;
    logic        expiry;
    logic        start_req;
    logic [31:0] start_us;
    logic        stuck;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    oneshot_arm_ctrl #(
        .TB_W(32), .US_W(32), .TICKS_PER_US(4),
        .MIN_US(500), .MAX_UPD(2), .STUCK_US(10000)
    ) i_oneshot_arm_ctrl (
        .clk(clk), .rst(rst), .tgt_valid(tgt_valid), .tgt_time(tgt_time),
        .now(now), .cmd_done(cmd_done), .cmd_ok(cmd_ok), .expiry(expiry),
        .start_req(start_req), .start_us(start_us), .stuck(stuck)
    );

    typedef struct packed {
        logic        tv;
        logic [31:0] tgt;
        logic [31:0] tnow;
        logic        dn;
        logic        ok;
        logic        ex;
        logic        ereq;
        logic [31:0] eus;
        logic        estk;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'd0,     32'd0,     1'b0, 1'b0, 1'b0, 1'b0, 32'd0,    1'b0, 8'd10}, // R10 idle
        '{1'b1, 32'd10000, 32'd1000,  1'b0, 1'b0, 1'b0, 1'b1, 32'd2250, 1'b0, 8'd2},  // R2
        '{1'b1, 32'd8000,  32'd1010,  1'b0, 1'b0, 1'b0, 1'b0, 32'd0,    1'b0, 8'd11}, // R11 busy
        '{1'b1, 32'd9000,  32'd1020,  1'b0, 1'b0, 1'b0, 1'b0, 32'd0,    1'b0, 8'd5},  // R5 later dropped
        '{1'b0, 32'd0,     32'd1030,  1'b1, 1'b1, 1'b0, 1'b0, 32'd0,    1'b0, 8'd7},  // R7 stamp 10030
        '{1'b0, 32'd0,     32'd1040,  1'b0, 1'b0, 1'b0, 1'b1, 32'd1740, 1'b0, 8'd5},  // R5 earliest sent
        '{1'b0, 32'd0,     32'd1050,  1'b1, 1'b1, 1'b0, 1'b0, 32'd0,    1'b0, 8'd7},  // R7 stamp 8010
        '{1'b1, 32'd5001,  32'd1060,  1'b0, 1'b0, 1'b0, 1'b0, 32'd0,    1'b0, 8'd4},  // R4 limit
        '{1'b0, 32'd0,     32'd1070,  1'b0, 1'b0, 1'b1, 1'b0, 32'd0,    1'b0, 8'd4},  // R4 expiry
        '{1'b1, 32'd5001,  32'd1080,  1'b0, 1'b0, 1'b0, 1'b0, 32'd0,    1'b0, 8'd6},  // R6 equal
        '{1'b1, 32'd3001,  32'd1090,  1'b0, 1'b0, 1'b0, 1'b1, 32'd500,  1'b0, 8'd1},  // R1 floor
        '{1'b0, 32'd0,     32'd1100,  1'b1, 1'b1, 1'b0, 1'b0, 32'd0,    1'b0, 8'd7},  // R7 stamp 3100
        '{1'b1, 32'd3050,  32'd1110,  1'b0, 1'b0, 1'b0, 1'b0, 32'd0,    1'b0, 8'd3},  // R3 short
        '{1'b1, 32'd4000,  32'd1120,  1'b0, 1'b0, 1'b0, 1'b0, 32'd0,    1'b0, 8'd3},  // R3 later
        '{1'b1, 32'd2000,  32'd3200,  1'b0, 1'b0, 1'b0, 1'b0, 32'd0,    1'b0, 8'd3},  // R3 passed
        '{1'b0, 32'd0,     32'd3300,  1'b0, 1'b0, 1'b1, 1'b0, 32'd0,    1'b0, 8'd4},  // R4 expiry
        '{1'b1, 32'd11301, 32'd3300,  1'b0, 1'b0, 1'b0, 1'b1, 32'd2001, 1'b0, 8'd2},  // R2 round up
        '{1'b1, 32'd9000,  32'd3310,  1'b0, 1'b0, 1'b0, 1'b0, 32'd0,    1'b0, 8'd5},  // R5 recorded
        '{1'b0, 32'd0,     32'd3320,  1'b1, 1'b0, 1'b0, 1'b0, 32'd0,    1'b0, 8'd9},  // R9 failure
        '{1'b0, 32'd0,     32'd3330,  1'b0, 1'b0, 1'b0, 1'b1, 32'd1418, 1'b0, 8'd9},  // R9 retry
        '{1'b0, 32'd0,     32'd3340,  1'b1, 1'b1, 1'b0, 1'b0, 32'd0,    1'b0, 8'd7},  // R7 stamp 9012
        '{1'b0, 32'd0,     32'd49012, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0,    1'b0, 8'd8},  // R8 at edge
        '{1'b0, 32'd0,     32'd49013, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0,    1'b1, 8'd8},  // R8 trips
        '{1'b0, 32'd0,     32'd49020, 1'b0, 1'b0, 1'b1, 1'b0, 32'd0,    1'b1, 8'd8},  // R8 sticky
        '{1'b1, 32'd60000, 32'd49030, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0,    1'b1, 8'd8}   // R8 no start
    };

    task automatic chk(input logic ok, input int rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: got %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic drive(input logic tv, input logic [31:0] tg, input logic [31:0] tn,
                         input logic dn, input logic ok, input logic ex);
        tgt_valid = tv; tgt_time = tg; now = tn;
        cmd_done = dn; cmd_ok = ok; expiry = ex;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired: got %0d expected %0d", cycles, 20000);
            finish_run();
        end
    end

    initial begin
        rst = 1'b1;
        tgt_valid = 1'b0; tgt_time = '0; now = '0;
        cmd_done = 1'b0; cmd_ok = 1'b0; expiry = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(start_req == 1'b0, 10, "reset start_req", start_req, 0);  // R10
        chk(stuck == 1'b0, 10, "reset stuck", stuck, 0);              // R10
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            drive(VECS[k].tv, VECS[k].tgt, VECS[k].tnow, VECS[k].dn, VECS[k].ok, VECS[k].ex);
            chk(start_req == VECS[k].ereq, int'(VECS[k].rq), $sformatf("step %0d start_req", k),
                start_req, VECS[k].ereq);
            if (VECS[k].ereq)
                chk(start_us == VECS[k].eus, int'(VECS[k].rq), $sformatf("step %0d start_us", k),
                    start_us, VECS[k].eus);
            chk(stuck == VECS[k].estk, int'(VECS[k].rq), $sformatf("step %0d stuck", k),
                stuck, VECS[k].estk);
        end

        // R10: reset clears the stuck state and the running timer
        rst = 1'b1;
        drive(1'b0, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0);
        drive(1'b0, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        chk(stuck == 1'b0, 10, "stuck after reset", stuck, 0);
        chk(start_req == 1'b0, 10, "start_req after reset", start_req, 0);

        // R1: a target already in the past gets the minimum count
        drive(1'b1, 32'd100, 32'd500, 1'b0, 1'b0, 1'b0);
        chk(start_req == 1'b1, 1, "past target start_req", start_req, 1);
        chk(start_us == 32'd500, 1, "past target count", start_us, 500);

        // R11: held back while awaiting completion, even for an earlier target
        drive(1'b1, 32'd50, 32'd510, 1'b0, 1'b0, 1'b0);
        chk(start_req == 1'b0, 11, "no start while busy", start_req, 0);

        // R2: exactly 2001 ticks ahead rounds up to 501 us (after completion, pending 50 runs at 520)
        drive(1'b0, 32'd0, 32'd515, 1'b1, 1'b0, 1'b0);
        drive(1'b0, 32'd0, 32'd520, 1'b0, 1'b0, 1'b0);
        chk(start_req == 1'b1 && start_us == 32'd500, 5, "pending past target sent", start_us, 500);
        drive(1'b0, 32'd0, 32'd530, 1'b1, 1'b0, 1'b0);
        drive(1'b0, 32'd0, 32'd540, 1'b0, 1'b0, 1'b1);
        drive(1'b1, 32'd2541, 32'd540, 1'b0, 1'b0, 1'b0);
        chk(start_req == 1'b1, 2, "boundary start_req", start_req, 1);
        chk(start_us == 32'd501, 2, "boundary round up", start_us, 501);

        finish_run();
    end
endmodule